// File: doc/BRIEF.md
# SPI Serial RAM Word Controller

This block is the master side of a link to an external serial RAM. A single request strobe starts one complete chip-enable frame. The frame can be a 32-bit word read, a 32-bit word write, an identification probe, a device reset, an entry into deep power-down, or a wake-up from deep power-down. The controller builds the command and address bytes itself and clocks the data in or out one bit per serial clock. It closes the frame and then signals completion with a single-cycle `done`.

The serial link runs in SPI mode 0. The serial clock idles low and each byte travels most-significant bit first. The three address bytes go out high byte first. The four data bytes go out low byte first, in both directions. The identification probe reports a match through a flag. A wake-up does not clock the link: it holds chip enable low for a set number of system clocks and then releases it.

Top module: `spiram_word_ctrl`

## Requirements
- R1: Operation code 0 (read): one chip-enable frame sends 0x03, then address bits 23:16, 15:8 and 7:0, then runs 32 more serial clocks with MOSI low. The first byte received becomes `rdata[7:0]` and the fourth becomes `rdata[31:24]`.
- R2: Operation code 1 (write): one frame sends 0x02, the three address bytes high first, then `wdata[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`, for 64 serial clocks in total.
- R3: Operation code 2 (identify): one frame sends 0x9F and three zero bytes, then receives eight bytes. `idValid` is set only if the first received byte is 0x5D. Any accepted request clears it.
- R4: Operation code 3 (reset): one frame of 16 serial clocks carries 0x66 and then 0x99.
- R5: Operation code 4 (sleep): one frame of 8 serial clocks carries 0xB9.
- R6: Operation code 5 (wake): chip enable stays low for exactly HOLD_CYCLES system clocks with no serial clock edge. HOLD_CYCLES defaults to CLK_HZ/1000.
- R7: Each bit lasts DIV system clocks. SCLK is low for DIV-DIV/2 clocks and then high for DIV/2 clocks. SCLK is low whenever chip enable is high. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R8: Chip enable falls at least one system clock before the first rising SCLK edge. It stays high for at least two system clocks between frames.
- R9: `busy` is high from the cycle after a request is accepted through the `done` cycle. Requests seen while `busy` is high are ignored, and so are operation codes 6 and 7.
- R10: `done` is a one-cycle pulse in the second cycle after chip enable returns high. `rdata` and `idValid` hold their values from `done` until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled while idle |
| op | input | 3 | Operation code |
| addr | input | 24 | Word address |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Frame in progress |
| idValid | output | 1 | Identification matched |
| ceN | output | 1 | Chip enable, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the RAM |
| miso | input | 1 | Serial data from the RAM |

## Verification
The risky overlap is a new request that arrives in the same cycle as the completion pulse. In that cycle `busy` is still high, so the request must be dropped. The identical request one cycle later must start a frame with exactly three chip-enable-high cycles before it. The bench raises `req` during the `done` cycle and again in the next cycle. Its per-cycle model expects no frame from the first and a complete frame from the second, and it compares chip enable, SCLK, MOSI, `busy` and `done` on every clock. A stray request in the middle of a write frame is judged the same way.

// File: rtl/spiram_pkg.sv
package spiram_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_IDENT = 3'd2,
    OP_RESET = 3'd3,
    OP_SLEEP = 3'd4,
    OP_WAKE  = 3'd5
  } opCode_t;

  typedef struct packed {
    logic    load;
    logic    sample;
    logic    shift;
    logic    capture;
    opCode_t op;
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_WRITE  = 8'h02;
  localparam logic [7:0] CMD_IDENT  = 8'h9F;
  localparam logic [7:0] CMD_RSTEN  = 8'h66;
  localparam logic [7:0] CMD_RST    = 8'h99;
  localparam logic [7:0] CMD_SLEEP  = 8'hB9;
  localparam logic [7:0] IDENT_WANT = 8'h5D;

endpackage

// File: rtl/spiram_ctrl.sv
module spiram_ctrl
  import spiram_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int HOLD_CYCLES = 125000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [2:0] op,
  output logic       busy,
  output logic       done,
  output logic       ceN,
  output logic       sclk,
  output dpStrobe_t  strb
);
  localparam int LOW    = DIV - DIV / 2;
  localparam int PH_W   = $clog2(DIV);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_HOLD, S_GAP, S_DONE} state_t;

  state_t          state;
  logic [PH_W-1:0] phase;
  logic [6:0]      bitIdx;
  logic [6:0]      lastBit;
  logic [HOLD_W-1:0] holdCnt;
  opCode_t         opReg;
  logic            accept, phEnd, lastIdx;

  function automatic logic [6:0] frameBits(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: frameBits = 7'd64;
      3'd2:       frameBits = 7'd96;
      3'd3:       frameBits = 7'd16;
      3'd4:       frameBits = 7'd8;
      default:    frameBits = 7'd0;
    endcase
  endfunction

  assign accept  = (state == S_IDLE) && req && (op <= 3'd5);
  assign phEnd   = (phase == PH_W'(DIV - 1));
  assign lastIdx = (bitIdx == lastBit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= '0;
      bitIdx  <= '0;
      lastBit <= '0;
      holdCnt <= '0;
      opReg   <= OP_READ;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          opReg   <= opCode_t'(op);
          phase   <= '0;
          bitIdx  <= '0;
          holdCnt <= '0;
          lastBit <= frameBits(op) - 7'd1;
          state   <= (op == 3'd5) ? S_HOLD : S_SHIFT;
        end
        S_SHIFT: begin
          if (phEnd) begin
            phase <= '0;
            if (lastIdx) state <= S_GAP;
            else         bitIdx <= bitIdx + 7'd1;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        S_HOLD: begin
          if (holdCnt == HOLD_W'(HOLD_CYCLES - 1)) state <= S_GAP;
          else holdCnt <= holdCnt + HOLD_W'(1);
        end
        S_GAP:  state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.op      = accept ? opCode_t'(op) : opReg;
    strb.sample  = (state == S_SHIFT) && (phase == PH_W'(LOW - 1));
    strb.shift   = (state == S_SHIFT) && phEnd && !lastIdx;
    strb.capture = (state == S_SHIFT) && phEnd && lastIdx;
  end

  assign sclk = (state == S_SHIFT) && (phase >= PH_W'(LOW));
  assign ceN  = !((state == S_SHIFT) || (state == S_HOLD));
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/spiram_dp.sv
module spiram_dp
  import spiram_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStrobe_t   strb,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  input  logic        miso,
  output logic        mosi,
  output logic [31:0] rdata,
  output logic        idValid
);
  logic [63:0] txShift;
  logic [63:0] rxShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      rdata   <= '0;
      idValid <= 1'b0;
    end else begin
      if (strb.load) begin
        idValid <= 1'b0;
        case (strb.op)
          OP_READ:  txShift <= {CMD_READ, addr, 32'h0};
          OP_WRITE: txShift <= {CMD_WRITE, addr, wdata[7:0], wdata[15:8],
                                wdata[23:16], wdata[31:24]};
          OP_IDENT: txShift <= {CMD_IDENT, 56'h0};
          OP_RESET: txShift <= {CMD_RSTEN, CMD_RST, 48'h0};
          OP_SLEEP: txShift <= {CMD_SLEEP, 56'h0};
          default:  txShift <= '0;
        endcase
      end
      if (strb.shift)  txShift <= {txShift[62:0], 1'b0};
      if (strb.sample) rxShift <= {rxShift[62:0], miso};
      if (strb.capture) begin
        if (strb.op == OP_READ)
          rdata <= {rxShift[7:0], rxShift[15:8], rxShift[23:16], rxShift[31:24]};
        if (strb.op == OP_IDENT)
          idValid <= (rxShift[63:56] == IDENT_WANT);
      end
    end
  end

  assign mosi = txShift[63];

endmodule

// File: rtl/spiram_word_ctrl.sv
module spiram_word_ctrl
  import spiram_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int CLK_HZ      = 125_000_000,
  parameter int HOLD_CYCLES = CLK_HZ / 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [2:0]  op,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        done,
  output logic        busy,
  output logic        idValid,
  output logic        ceN,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  dpStrobe_t strb;

  spiram_ctrl #(.DIV(DIV), .HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .req(req), .op(op),
    .busy(busy), .done(done), .ceN(ceN), .sclk(sclk), .strb(strb)
  );

  spiram_dp uDp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .wdata(wdata),
    .miso(miso), .mosi(mosi), .rdata(rdata), .idValid(idValid)
  );

endmodule

// File: rtl/spiram_word_ctrl_chk.sv
module spiram_word_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        ceN,
  input logic        sclk,
  input logic        mosi,
  input logic        done,
  input logic        busy,
  input logic        idValid,
  input logic [31:0] rdata
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    ceN |-> !sclk); // R7
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R7
  AST_CE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(ceN) |-> !sclk); // R8
  AST_CE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ceN) |=> ceN); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
    done |-> (ceN && $past(ceN))); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> ($stable(rdata) && $stable(idValid))); // R10
endmodule

bind spiram_word_ctrl spiram_word_ctrl_chk uChk (
  .clk(clk), .rst(rst), .ceN(ceN), .sclk(sclk), .mosi(mosi),
  .done(done), .busy(busy), .idValid(idValid), .rdata(rdata)
);

// File: tb/spiram_word_ctrl_test.sv
`timescale 1ns/1ps
module spiram_word_ctrl_test;
  localparam int DIV  = 3;
  localparam int HOLD = 20;
  localparam int LOW  = DIV - DIV / 2;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, miso;
  logic [2:0]  op = '0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic done, busy, idValid, ceN, sclk, mosi;

  int checks = 0, failures = 0;
  bit finished = 0;

  spiram_word_ctrl #(.DIV(DIV), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .idValid(idValid),
    .ceN(ceN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  // RAM side: returns resp bits MSB first, one per rising SCLK
  logic [95:0] resp = '0;
  int sCnt = 0;
  always @(posedge sclk or posedge ceN) begin
    if (ceN) sCnt <= 0;
    else     sCnt <= sCnt + 1;
  end
  assign miso = (sCnt < 96) ? resp[95 - sCnt] : 1'b0;

  typedef struct {
    bit ce; bit sck; int mo; bit dn; bit bz; bit chk;
    logic [31:0] rd; bit idv;
  } exp_t;
  exp_t q[$];
  exp_t e;
  logic [31:0] mRdata = '0;
  bit mIdv = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{ce:1, sck:0, mo:-1, dn:0, bz:0, chk:1, rd:mRdata, idv:mIdv};
      chk(ceN === e.ce,  "R8/R6 ceN",  {31'h0, ceN},  {31'h0, e.ce});
      chk(sclk === e.sck, "R7 sclk",   {31'h0, sclk}, {31'h0, e.sck});
      chk(done === e.dn, "R10 done",   {31'h0, done}, {31'h0, e.dn});
      chk(busy === e.bz, "R9 busy",    {31'h0, busy}, {31'h0, e.bz});
      if (e.mo >= 0)
        chk(mosi === e.mo[0], "R1/R2/R4/R5 mosi", {31'h0, mosi}, {31'h0, e.mo[0]});
      if (e.chk) begin
        chk(rdata === e.rd, "R1 rdata", rdata, e.rd);
        chk(idValid === e.idv, "R3 idValid", {31'h0, idValid}, {31'h0, e.idv});
      end
      if (e.dn) begin mRdata = e.rd; mIdv = e.idv; end
    end
  end

  task automatic pushTail(input logic [31:0] rd, input bit idv);
    q.push_back('{ce:1, sck:0, mo:-1, dn:0, bz:1, chk:0, rd:0, idv:0});
    q.push_back('{ce:1, sck:0, mo:-1, dn:1, bz:1, chk:1, rd:rd, idv:idv});
  endtask

  task automatic pushFrame(input int nBits, input logic [63:0] tx, input logic [31:0] rd, input bit idv);
    for (int i = 0; i < nBits; i++)
      for (int p = 0; p < DIV; p++)
        q.push_back('{ce:0, sck:(p >= LOW), mo:((i < 64) ? int'(tx[63-i]) : 0),
                      dn:0, bz:1, chk:0, rd:0, idv:0});
    pushTail(rd, idv);
  endtask

  // call at a negedge while the model says the block is idle
  task automatic issue(input logic [2:0] o, input logic [23:0] a, input logic [31:0] w,
                       input logic [95:0] r);
    logic [7:0] b0, b1, b2, b3;
    req = 1'b1; op = o; addr = a; wdata = w; resp = r;
    b0 = r[63:56]; b1 = r[55:48]; b2 = r[47:40]; b3 = r[39:32];
    case (o)
      3'd0: pushFrame(64, {8'h03, a, 32'h0}, {b3, b2, b1, b0}, 0);
      3'd1: pushFrame(64, {8'h02, a, w[7:0], w[15:8], w[23:16], w[31:24]}, mRdata, 0);
      3'd2: pushFrame(96, {8'h9F, 56'h0}, mRdata, r[63:56] == 8'h5D);
      3'd3: pushFrame(16, {8'h66, 8'h99, 48'h0}, mRdata, 0);
      3'd4: pushFrame(8, {8'hB9, 56'h0}, mRdata, 0);
      3'd5: begin
        for (int i = 0; i < HOLD; i++)
          q.push_back('{ce:0, sck:0, mo:-1, dn:0, bz:1, chk:0, rd:0, idv:0});
        pushTail(mRdata, 0);
      end
      default: ;
    endcase
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic poke(input logic [2:0] o);
    req = 1'b1; op = o;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ceN === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R10 reset idle", {28'h0, ceN, sclk, busy, done}, 32'h8);
    chk(rdata === 32'h0 && idValid === 1'b0, "R3 reset result", rdata, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R3: match
    issue(3'd2, 24'h0, 32'h0, {32'hFFFF_FFFF, 8'h5D, 56'hA5A5_A5A5_A5A5_A5});
    drain(); @(negedge clk);
    // R1: read clears idValid, byte order check
    issue(3'd0, 24'h123456, 32'h0, {32'hFFFF_FFFF, 32'hA1B2_C3D4, 32'hFFFF_FFFF});
    drain(); @(negedge clk);
    issue(3'd0, 24'hFEDCBA, 32'h0, {32'h0, 32'h8001_FF00, 32'h0});
    drain(); @(negedge clk);
    // R2 write with a stray request mid frame (R9)
    issue(3'd1, 24'hABCDEF, 32'h1122_3344, '0);
    repeat (20) @(negedge clk);
    poke(3'd0);
    drain(); @(negedge clk);
    // R3: mismatch
    issue(3'd2, 24'h0, 32'h0, {32'h0, 8'h5C, 56'h0});
    drain(); @(negedge clk);
    // R4 then R5, with a request in the done cycle (R9) and the next cycle
    issue(3'd3, 24'h0, 32'h0, '0);
    drain();
    poke(3'd2);
    issue(3'd4, 24'h0, 32'h0, '0);
    drain(); @(negedge clk);
    // R6 wake
    issue(3'd5, 24'h0, 32'h0, '0);
    drain(); @(negedge clk);
    // R9 unused codes ignored
    poke(3'd6);
    poke(3'd7);
    repeat (5) @(negedge clk);
    // idValid set then cleared by a write
    issue(3'd2, 24'h0, 32'h0, {32'h0, 8'h5D, 56'h0});
    drain();
    @(negedge clk);
    issue(3'd1, 24'h000001, 32'hDEAD_BEEF, '0);
    drain();
    repeat (6) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule